// File: doc/BRIEF.md
# Write-Only-Eviction Pixel Cache

This block is a direct-mapped pixel cache that sits beside one rasterizer. Each line holds a block of depth words and the block of color words at the same screen position. The two blocks share one valid bit. Each line also keeps its own depth tag and color tag. The rasterizer issues three kinds of request: depth read, depth write and color write. Only a depth read decides hit or miss, and it does so by comparing the depth tag alone.

A miss never fetches anything from the frame buffer. The line that occupied the slot is pushed, whole, onto an outbound memory queue as a single record. In the same cycle the slot is reset in place to all-ones, which stands for the farthest depth and the background color. The merge logic downstream resolves overlap between rasterizers, so the cache may hold stale data without harm. At the end of a frame, a flush walks every line and pushes each valid one exactly as a miss would. It leaves the cache invalid and ready for the next frame.

Top module: `pxc_top`

## Requirements
- R1: After reset every line is invalid and holds all-ones depth and color; `stall`, `q_push`, `rd_valid` and `flush_busy` are 0.
- R2: A depth read (`req_op` = 0) to a valid line whose depth tag equals `req_tag` returns the stored depth word at `req_off`, without stall and without a push.
- R3: A depth read to an invalid line marks it valid, loads its depth tag from `req_tag` and returns all-ones; it pushes nothing.
- R4: A depth read to a valid line with a different depth tag pushes that line in the same cycle. The pushed record carries the old depth tag, the old color tag, the index and both data blocks. The read returns all-ones, and the slot then belongs to the new tag with all-ones data.
- R5: The color tag takes no part in the hit decision: a depth read whose depth tag matches hits whatever the stored color tag is.
- R6: While a push is wanted and `q_full` is 1, `stall` is 1, `q_push` is 0 and the request is not accepted. The push happens in the first cycle that `q_full` is 0.
- R7: Only valid lines are ever pushed; invalid lines produce no queue record.
- R8: A one-cycle `flush_start` raises `flush_busy` on the next cycle. The flush pushes every valid line once, in ascending index order. Afterwards every line is invalid with all-ones data, so a following depth read behaves as in R3.
- R9: A depth write (`req_op` = 1) stores `req_wdata` into the depth word at `req_off`. A color write (`req_op` = 2) stores `req_wdata` into the color word at `req_off` and loads the color tag from `req_tag`. Word w of a block occupies bits [w*DW +: DW] of the block vector.
- R10: `rd_valid` is 1 in the cycle after an accepted depth read, carrying `rd_data`, and 0 after any other request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; also the frame-start initialization |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 depth read, 1 depth write, 2 color write, 3 none |
| req_tag | input | TAG_W | Depth tag (reads) or color tag (color writes) |
| req_idx | input | log2(LINES) | Line index |
| req_off | input | log2(PIX) | Word within the block |
| req_wdata | input | DW | Write data |
| rd_valid | output | 1 | Depth read result valid |
| rd_data | output | DW | Depth read result |
| stall | output | 1 | Push blocked by a full queue; hold the request |
| flush_start | input | 1 | Pulse to begin the end-of-frame flush |
| flush_busy | output | 1 | Flush in progress; requests are ignored |
| q_full | input | 1 | Outbound queue has no free entry |
| q_push | output | 1 | Record written to the queue this cycle |
| q_idx | output | log2(LINES) | Line index of the record |
| q_dtag | output | TAG_W | Depth tag of the record |
| q_ctag | output | TAG_W | Color tag of the record |
| q_depth | output | PIX*DW | Depth block of the record |
| q_color | output | PIX*DW | Color block of the record |

## Verification
The bench first drives a slot that has never been touched. A design that counted this first access as a miss would push an empty record, and the scoreboard flags it as an unexpected push. It then places a color tag that differs from the depth tag and does a depth read. A design that compared the color tag would evict on what is really a hit. A miss is also held against a full queue for several cycles. A design that pushed anyway, or that dropped or re-applied the request, shows a lost or doubled record, or a wrong result word. The flush runs over a sparse set of valid lines. Pushes out of index order, a record for an empty line, or lines left valid afterwards each show up as a record mismatch or as a push on the read after the flush.

// File: rtl/pxc_pkg.sv
package pxc_pkg;
   typedef enum logic [1:0] {
      OP_ZREAD  = 2'd0,
      OP_ZWRITE = 2'd1,
      OP_CWRITE = 2'd2,
      OP_NONE   = 2'd3
   } pxc_op_e;
endpackage

// File: rtl/pxc_line_store.sv
module pxc_line_store #(
   parameter int LINES = 16,
   parameter int PIX   = 4,
   parameter int DW    = 16,
   parameter int TAG_W = 8,
   localparam int IW   = $clog2(LINES),
   localparam int OW   = $clog2(PIX),
   localparam int BW   = PIX * DW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IW-1:0]    rd_idx,
   output logic             ln_valid,
   output logic [TAG_W-1:0] ln_dtag,
   output logic [TAG_W-1:0] ln_ctag,
   output logic [BW-1:0]    ln_depth,
   output logic [BW-1:0]    ln_color,
   output logic             any_valid,
   input  logic             ev_en,
   input  logic             ev_valid,
   input  logic [TAG_W-1:0] ev_dtag,
   input  logic             zw_en,
   input  logic             cw_en,
   input  logic [IW-1:0]    wr_idx,
   input  logic [OW-1:0]    wr_off,
   input  logic [DW-1:0]    wr_data,
   input  logic [TAG_W-1:0] wr_ctag
);
   logic [LINES-1:0] valid_v;
   logic [TAG_W-1:0] dtag_a  [LINES];
   logic [TAG_W-1:0] ctag_a  [LINES];
   logic [BW-1:0]    depth_a [LINES];
   logic [BW-1:0]    color_a [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic             v_q;
      logic [TAG_W-1:0] dt_q, ct_q;
      logic [BW-1:0]    d_q, c_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q  <= 1'b0;
            dt_q <= '0;
            ct_q <= '0;
            d_q  <= '1;
            c_q  <= '1;
         end else if (ev_en && rd_idx == IW'(g)) begin
            v_q  <= ev_valid;
            dt_q <= ev_dtag;
            ct_q <= '0;
            d_q  <= '1;
            c_q  <= '1;
         end else begin
            if (zw_en && wr_idx == IW'(g))
               d_q[int'(wr_off)*DW +: DW] <= wr_data;
            if (cw_en && wr_idx == IW'(g)) begin
               c_q[int'(wr_off)*DW +: DW] <= wr_data;
               ct_q <= wr_ctag;
            end
         end
      end
      assign valid_v[g] = v_q;
      assign dtag_a[g]  = dt_q;
      assign ctag_a[g]  = ct_q;
      assign depth_a[g] = d_q;
      assign color_a[g] = c_q;
   end

   assign ln_valid  = valid_v[rd_idx];
   assign ln_dtag   = dtag_a[rd_idx];
   assign ln_ctag   = ctag_a[rd_idx];
   assign ln_depth  = depth_a[rd_idx];
   assign ln_color  = color_a[rd_idx];
   assign any_valid = |valid_v;

   // An eviction never coincides with a data write in the same cycle
   AST_EV_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      ev_en |-> !(zw_en || cw_en));  // R4
endmodule

// File: rtl/pxc_ctrl.sv
module pxc_ctrl
   import pxc_pkg::*;
#(
   parameter int LINES = 16,
   parameter int PIX   = 4,
   parameter int DW    = 16,
   parameter int TAG_W = 8,
   localparam int IW   = $clog2(LINES),
   localparam int OW   = $clog2(PIX),
   localparam int BW   = PIX * DW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [1:0]       req_op,
   input  logic [TAG_W-1:0] req_tag,
   input  logic [IW-1:0]    req_idx,
   input  logic [OW-1:0]    req_off,
   input  logic             flush_start,
   input  logic             q_full,
   input  logic             ln_valid,
   input  logic [TAG_W-1:0] ln_dtag,
   input  logic [BW-1:0]    ln_depth,
   input  logic             any_valid,
   output logic [IW-1:0]    rd_idx,
   output logic             ev_en,
   output logic             ev_valid,
   output logic             zw_en,
   output logic             cw_en,
   output logic             q_push,
   output logic             stall,
   output logic             flush_busy,
   output logic             rd_valid,
   output logic [DW-1:0]    rd_data
);
   logic          busy_q;
   logic [IW-1:0] ptr_q;
   logic          zr, hit, miss, claim, fl_ev, need_push, advance;
   pxc_op_e       op;

   assign op        = pxc_op_e'(req_op);
   assign rd_idx    = busy_q ? ptr_q : req_idx;
   assign zr        = req_valid && !busy_q && op == OP_ZREAD;
   assign hit       = zr && ln_valid && ln_dtag == req_tag;
   assign miss      = zr && ln_valid && ln_dtag != req_tag;
   assign claim     = zr && !ln_valid;
   assign fl_ev     = busy_q && ln_valid;
   assign need_push = miss || fl_ev;
   assign q_push    = need_push && !q_full;
   assign stall     = need_push && q_full;
   assign ev_en     = q_push || claim;
   assign ev_valid  = !busy_q;
   assign zw_en     = req_valid && !busy_q && op == OP_ZWRITE;
   assign cw_en     = req_valid && !busy_q && op == OP_CWRITE;
   assign advance   = busy_q && !(fl_ev && q_full);
   assign flush_busy = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         ptr_q  <= '0;
      end else if (!busy_q) begin
         busy_q <= flush_start;
         ptr_q  <= '0;
      end else if (advance) begin
         ptr_q  <= ptr_q + 1'b1;
         if (ptr_q == IW'(LINES - 1)) busy_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= zr && !stall;
         if (zr && !stall)
            rd_data <= hit ? ln_depth[int'(req_off)*DW +: DW] : '1;
      end
   end

   AST_STALL_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> q_full);  // R6
   AST_PUSH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      q_push |-> ln_valid);  // R7
   AST_NO_PUSH_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> !q_push && !stall);  // R2
   AST_CLAIM_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      claim |-> !q_push && !stall);  // R3
   AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> !any_valid);  // R8
   AST_RD_ONLY_ZREAD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && op != OP_ZREAD) |=> !rd_valid);  // R10
endmodule

// File: rtl/pxc_top.sv
module pxc_top #(
   parameter int LINES = 16,
   parameter int PIX   = 4,
   parameter int DW    = 16,
   parameter int TAG_W = 8,
   localparam int IW   = $clog2(LINES),
   localparam int OW   = $clog2(PIX),
   localparam int BW   = PIX * DW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [1:0]       req_op,
   input  logic [TAG_W-1:0] req_tag,
   input  logic [IW-1:0]    req_idx,
   input  logic [OW-1:0]    req_off,
   input  logic [DW-1:0]    req_wdata,
   output logic             rd_valid,
   output logic [DW-1:0]    rd_data,
   output logic             stall,
   input  logic             flush_start,
   output logic             flush_busy,
   input  logic             q_full,
   output logic             q_push,
   output logic [IW-1:0]    q_idx,
   output logic [TAG_W-1:0] q_dtag,
   output logic [TAG_W-1:0] q_ctag,
   output logic [BW-1:0]    q_depth,
   output logic [BW-1:0]    q_color
);
   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("LINES must be a power of two, at least 2");
   end
   if (PIX < 2 || (PIX & (PIX - 1)) != 0) begin : g_bad_pix
      $error("PIX must be a power of two, at least 2");
   end
   if (DW < 1 || TAG_W < 1) begin : g_bad_width
      $error("DW and TAG_W must be positive");
   end

   logic             ln_valid, any_valid, ev_en, ev_valid, zw_en, cw_en;
   logic [TAG_W-1:0] ln_dtag;
   logic [IW-1:0]    rd_idx;

   pxc_ctrl #(.LINES(LINES), .PIX(PIX), .DW(DW), .TAG_W(TAG_W)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_tag(req_tag), .req_idx(req_idx), .req_off(req_off),
      .flush_start(flush_start), .q_full(q_full), .ln_valid(ln_valid),
      .ln_dtag(ln_dtag), .ln_depth(q_depth), .any_valid(any_valid),
      .rd_idx(rd_idx), .ev_en(ev_en), .ev_valid(ev_valid),
      .zw_en(zw_en), .cw_en(cw_en), .q_push(q_push), .stall(stall),
      .flush_busy(flush_busy), .rd_valid(rd_valid), .rd_data(rd_data));

   pxc_line_store #(.LINES(LINES), .PIX(PIX), .DW(DW), .TAG_W(TAG_W)) store_i (
      .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .ln_valid(ln_valid),
      .ln_dtag(ln_dtag), .ln_ctag(q_ctag), .ln_depth(q_depth),
      .ln_color(q_color), .any_valid(any_valid), .ev_en(ev_en),
      .ev_valid(ev_valid), .ev_dtag(req_tag), .zw_en(zw_en), .cw_en(cw_en),
      .wr_idx(req_idx), .wr_off(req_off), .wr_data(req_wdata),
      .wr_ctag(req_tag));

   assign q_idx  = rd_idx;
   assign q_dtag = ln_dtag;
endmodule

// File: tb/pxc_top_tb_top.sv
module pxc_top_tb_top;
   localparam int L = 16, P = 4, DW = 16, TW = 8, IW = 4, OW = 2, BW = P * DW;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, flush_start = 1'b0, q_full = 1'b0;
   logic [1:0] req_op = 2'd3;
   logic [TW-1:0] req_tag = '0;
   logic [IW-1:0] req_idx = '0;
   logic [OW-1:0] req_off = '0;
   logic [DW-1:0] req_wdata = '0;
   logic rd_valid, stall, flush_busy, q_push;
   logic [DW-1:0] rd_data;
   logic [IW-1:0] q_idx;
   logic [TW-1:0] q_dtag, q_ctag;
   logic [BW-1:0] q_depth, q_color;

   always #5 clk = ~clk;

   pxc_top #(.LINES(L), .PIX(P), .DW(DW), .TAG_W(TW)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_tag(req_tag), .req_idx(req_idx), .req_off(req_off),
      .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
      .stall(stall), .flush_start(flush_start), .flush_busy(flush_busy),
      .q_full(q_full), .q_push(q_push), .q_idx(q_idx), .q_dtag(q_dtag),
      .q_ctag(q_ctag), .q_depth(q_depth), .q_color(q_color));

   typedef struct {
      logic [IW-1:0] idx;
      logic [TW-1:0] dtag, ctag;
      logic [BW-1:0] depth, color;
      string         req;
   } rec_t;

   rec_t exp_q[$];
   int total = 0, bad = 0;
   logic          mv  [L];
   logic [TW-1:0] mdt [L], mct [L];
   logic [BW-1:0] md  [L], mc  [L];

   task automatic check(input bit ok, input string req, input string what,
                        input logic [BW-1:0] act, input logic [BW-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Monitor: every push must match the next expected record
   always @(negedge clk) begin
      if (rst_n && q_push) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R7", "unexpected push idx", BW'(q_idx), '0);
         end else begin
            rec_t e;
            e = exp_q.pop_front();
            check(q_idx == e.idx, e.req, "push idx", BW'(q_idx), BW'(e.idx));
            check(q_dtag == e.dtag, e.req, "push dtag", BW'(q_dtag), BW'(e.dtag));
            check(q_ctag == e.ctag, e.req, "push ctag", BW'(q_ctag), BW'(e.ctag));
            check(q_depth == e.depth, e.req, "push depth", q_depth, e.depth);
            check(q_color == e.color, e.req, "push color", q_color, e.color);
         end
      end
   end

   task automatic model_evict(input int i, input string req);
      rec_t r;
      r.idx = IW'(i); r.dtag = mdt[i]; r.ctag = mct[i];
      r.depth = md[i]; r.color = mc[i]; r.req = req;
      exp_q.push_back(r);
   endtask

   task automatic model_reinit(input int i, input bit v, input logic [TW-1:0] t);
      mv[i] = v; mdt[i] = t; mct[i] = '0; md[i] = '1; mc[i] = '1;
   endtask

   // Drive one request; hold = cycles the queue is held full (misses only)
   task automatic drive(input logic [1:0] op, input logic [TW-1:0] tag,
                        input int idx, input int off, input logic [DW-1:0] d,
                        input int hold, input string req,
                        output logic rv, output logic [DW-1:0] rdat);
      @(posedge clk); #1;
      req_valid = 1'b1; req_op = op; req_tag = tag;
      req_idx = IW'(idx); req_off = OW'(off); req_wdata = d;
      if (hold > 0) q_full = 1'b1;
      @(negedge clk);
      for (int h = 0; h < hold; h++) begin
         check(stall === 1'b1 && q_push === 1'b0, "R6", "stall while full",
               BW'({stall, q_push}), BW'(2'b10));
         @(posedge clk); #1;
         if (h == hold - 1) q_full = 1'b0;
         @(negedge clk);
      end
      check(stall === 1'b0, req, "no stall", BW'(stall), '0);
      @(posedge clk); #1;
      req_valid = 1'b0; req_op = 2'd3;
      @(negedge clk);
      rv = rd_valid; rdat = rd_data;
   endtask

   task automatic zread(input logic [TW-1:0] tag, input int idx, input int off,
                        input int hold, input string req);
      logic [DW-1:0] e, r;
      logic rv;
      if (mv[idx] && mdt[idx] != tag) begin
         model_evict(idx, req);
         model_reinit(idx, 1'b1, tag);
         e = '1;
      end else if (mv[idx]) begin
         e = md[idx][off*DW +: DW];
      end else begin
         model_reinit(idx, 1'b1, tag);
         e = '1;
      end
      drive(2'd0, tag, idx, off, '0, hold, req, rv, r);
      check(rv === 1'b1, "R10", "rd_valid after read", BW'(rv), BW'(1));
      check(r === e, req, "read data", BW'(r), BW'(e));
   endtask

   task automatic zwrite(input int idx, input int off, input logic [DW-1:0] d);
      logic [DW-1:0] r;
      logic rv;
      md[idx][off*DW +: DW] = d;
      drive(2'd1, '0, idx, off, d, 0, "R9", rv, r);
      check(rv === 1'b0, "R10", "no rd_valid after write", BW'(rv), '0);
   endtask

   task automatic cwrite(input logic [TW-1:0] tag, input int idx, input int off,
                         input logic [DW-1:0] d);
      logic [DW-1:0] r;
      logic rv;
      mc[idx][off*DW +: DW] = d;
      mct[idx] = tag;
      drive(2'd2, tag, idx, off, d, 0, "R9", rv, r);
      check(rv === 1'b0, "R10", "no rd_valid after color write", BW'(rv), '0);
   endtask

   task automatic do_flush();
      int n;
      for (int i = 0; i < L; i++)
         if (mv[i]) begin
            model_evict(i, "R8");
            model_reinit(i, 1'b0, '0);
         end
      @(posedge clk); #1 flush_start = 1'b1;
      @(posedge clk); #1 flush_start = 1'b0;
      @(negedge clk);
      check(flush_busy === 1'b1, "R8", "flush_busy raised", BW'(flush_busy), BW'(1));
      n = 0;
      while (flush_busy === 1'b1 && n < 100) begin
         @(negedge clk);
         n++;
      end
      check(flush_busy === 1'b0, "R8", "flush finished", BW'(flush_busy), '0);
      check(exp_q.size() == 0, "R8", "records left", BW'(exp_q.size()), '0);
   endtask

   initial begin
      repeat (400) @(posedge clk);
      check(1'b0, "watchdog", "timeout", '0, '0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < L; i++) model_reinit(i, 1'b0, '0);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(stall === 1'b0 && q_push === 1'b0 && rd_valid === 1'b0 &&
            flush_busy === 1'b0, "R1", "idle after reset",
            BW'({stall, q_push, rd_valid, flush_busy}), '0);

      zread(8'h05, 3, 1, 0, "R3");           // first touch: ones, no push (R1 data)
      zwrite(3, 1, 16'h1234);
      zread(8'h05, 3, 1, 0, "R2");           // hit returns written word
      cwrite(8'h77, 3, 2, 16'hABCD);
      zread(8'h05, 3, 1, 0, "R5");           // color tag differs, still a hit
      zread(8'h09, 3, 1, 0, "R4");           // miss: record for tag 05
      zread(8'h09, 3, 1, 0, "R4");           // slot reset to ones, now a hit

      zread(8'h01, 7, 0, 0, "R3");
      zwrite(7, 0, 16'h0F0F);
      cwrite(8'h21, 7, 3, 16'h5555);
      zread(8'h02, 7, 0, 3, "R6");           // miss held by a full queue

      zread(8'h03, 0, 0, 0, "R3");
      zwrite(0, 3, 16'h00AA);
      zread(8'h04, 15, 2, 0, "R3");
      cwrite(8'h44, 15, 1, 16'hBEEF);
      zwrite(3, 0, 16'h7777);

      do_flush();                            // lines 0,3,7,15 in order (R7)
      zread(8'h09, 3, 0, 0, "R8");           // cleared: no push, ones
      zread(8'h02, 7, 0, 0, "R8");

      repeat (2) @(negedge clk);
      check(exp_q.size() == 0, "R7", "all records seen", BW'(exp_q.size()), '0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule